// File: doc/BRIEF.md
# SRAM-Emulated Ternary Match Table

This block provides a ternary lookup table that is built from an ordinary RAM instead of a match array. The RAM is `SD` words deep and `SW` bits wide. Each bit column holds one rule, and each word address stands for one value of a slice of the search key. The RAM is split into `N` equal sub-blocks of `SD/N` words. The search key is `N*log2(SD/N)` bits wide and is cut into `N` slices. Each slice addresses its own sub-block, and the `N` words read back are ANDed together. The result has one bit per rule, set when that rule matches the key.

A priority encoder turns the match vector into a hit flag and the index of the lowest-numbered matching rule. The result is registered. The RAM is physically one array, and its `N` sub-block reads are served by a time-multiplexed port. Because of that, a search finishes in a single system cycle.

A rule is written as a value and a don't-care mask. The block expands the pattern into one-hot column bits by walking every RAM address, one per cycle. While the walk runs, the block reports `busy` and turns away new searches and new updates. With the defaults `SD=16`, `SW=8` and `N=2`, a 16-word RAM holds 8 rules over a 6-bit key. Without the split, the same RAM would give only 4 key bits.

Top module: `tmt_match_table`

## Requirements
- R1: After reset, `busy` and `res_vld` are 0 and every stored bit is 0, so every search misses until a rule is written.
- R2: The search key is `N*CW` bits wide, where `CW = log2(SD/N)`. Slice `i` is `srch_key[i*CW +: CW]` and reads sub-block address `i*(SD/N) + slice`. The slices are therefore not interchangeable: a key with its slices swapped does not match a rule written for the unswapped key unless both are equal.
- R3: A rule is written with `upd_value` and `upd_mask`. A mask bit of 1 means don't care. A written rule matches a key exactly when the key equals the value on every bit whose mask bit is 0.
- R4: When one or more rules match, `res_hit` is 1 and `res_idx` is the smallest matching rule index.
- R5: When no rule matches, `res_hit` is 0 and `res_idx` is 0.
- R6: A search is accepted when `srch_vld` is 1 and `busy` is 0. `res_vld` is 1 in exactly the cycle after an accepted search, and 0 otherwise.
- R7: An update is accepted when `upd_vld` is 1 and `busy` is 0. `busy` is 1 from the next cycle on, for exactly `SD` cycles.
- R8: A search presented while `busy` is 1 is ignored and produces no `res_vld`.
- R9: An update presented while `busy` is 1 is ignored and leaves the table unchanged.
- R10: When a search and an update are accepted in the same cycle, the search result reflects the table as it was before that update.
- R11: Writing a rule again replaces its old pattern, so keys that matched only the old pattern stop matching that rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| srch_vld | input | 1 | Search request |
| srch_key | input | N*CW | Search key |
| upd_vld | input | 1 | Rule update request |
| upd_rule | input | log2(SW) | Rule index to write |
| upd_value | input | N*CW | Rule value |
| upd_mask | input | N*CW | Don't-care mask, 1 = ignore bit |
| busy | output | 1 | Update walk in progress |
| res_vld | output | 1 | Search result valid |
| res_hit | output | 1 | At least one rule matched |
| res_idx | output | log2(SW) | Lowest matching rule index |

## Verification
A search and the start of a rule update can land in the same cycle. The bench provokes this by raising `srch_vld` and `upd_vld` on the same edge while the block is idle. The expected result is computed from the bench's rule model before that update is applied, and the result must match it. Immediately afterwards the bench checks that `busy` holds for exactly `SD` cycles. While the walk is still running, the bench also injects a search and a second update. It checks that the search gives no result, and a later search confirms that the second update did not reach the table.

// File: rtl/tmt_pkg.sv
// Shared types for the SRAM-emulated ternary match table.
package tmt_pkg;
    // Rule-update sequencer states.
    typedef enum logic {
        UPD_IDLE = 1'b0,
        UPD_WALK = 1'b1
    } upd_state_e;
endpackage

// File: rtl/tmt_store.sv
// Rule store: an SD x SW bit array with one bit-granular write port and
// N read ports. The N read ports stand for one physical RAM that is
// time-multiplexed N times within a system cycle, so all N words are
// available in the same cycle. Assumes SW >= 2 and SD a power of two.
module tmt_store #(
    parameter int SD = 16,
    parameter int SW = 8,
    parameter int N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [$clog2(SD)-1:0] wr_addr,
    input  logic [$clog2(SW)-1:0] wr_rule,
    input  logic              wr_bit,
    input  logic [N*$clog2(SD)-1:0] rd_addr,
    output logic [N*SW-1:0]   rd_rows
);
    localparam int AW = $clog2(SD);

    logic [SW-1:0] mem [SD];

    // Clear the array on reset; otherwise write one rule bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < SD; a++) mem[a] <= '0;
        end else if (wr_en) begin
            mem[wr_addr][wr_rule] <= wr_bit;
        end
    end

    // One read port per sub-block slot of the multiplexed RAM.
    for (genvar i = 0; i < N; i++) begin : g_rd
        assign rd_rows[i*SW +: SW] = mem[rd_addr[i*AW +: AW]];
    end
endmodule

// File: rtl/tmt_updater.sv
// Rule-update sequencer: latches a rule index, a value and a don't-care
// mask, then visits every RAM address once, one per cycle. At each address
// it writes the rule's bit: 1 when the address's local offset agrees with
// the value slice of that sub-block on every cared-for bit, else 0.
// A start request is ignored while a walk is running.
module tmt_updater
    import tmt_pkg::*;
#(
    parameter int SD = 16,
    parameter int SW = 8,
    parameter int N  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [$clog2(SW)-1:0] rule,
    input  logic [N*$clog2(SD/N)-1:0] value,
    input  logic [N*$clog2(SD/N)-1:0] mask,
    output logic                  busy,
    output logic                  wr_en,
    output logic [$clog2(SD)-1:0] wr_addr,
    output logic [$clog2(SW)-1:0] wr_rule,
    output logic                  wr_bit
);
    localparam int SUB = SD / N;
    localparam int CW  = $clog2(SUB);
    localparam int AW  = $clog2(SD);
    localparam int KW  = N * CW;
    localparam int RIW = $clog2(SW);

    upd_state_e      state;
    logic [AW-1:0]   cnt;
    logic [RIW-1:0]  rule_q;
    logic [KW-1:0]   val_q;
    logic [KW-1:0]   msk_q;
    logic [CW-1:0]   loc;
    logic [CW-1:0]   vch;
    logic [CW-1:0]   mch;

    // Sequence the walk: latch the request, step the address, finish at SD-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= UPD_IDLE;
            cnt    <= '0;
            rule_q <= '0;
            val_q  <= '0;
            msk_q  <= '0;
        end else if (state == UPD_IDLE) begin
            if (start) begin
                state  <= UPD_WALK;
                cnt    <= '0;
                rule_q <= rule;
                val_q  <= value;
                msk_q  <= mask;
            end
        end else begin
            cnt <= cnt + 1'b1;
            if (cnt == AW'(SD - 1)) state <= UPD_IDLE;
        end
    end

    // Pick the value and mask slices that belong to the current sub-block.
    always_comb begin
        loc = CW'(int'(cnt) % SUB);
        vch = '0;
        mch = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(cnt) / SUB == i) begin
                vch = val_q[i*CW +: CW];
                mch = msk_q[i*CW +: CW];
            end
        end
    end

    // Drive the store's write port during the walk.
    always_comb begin
        busy    = (state == UPD_WALK);
        wr_en   = busy;
        wr_addr = cnt;
        wr_rule = rule_q;
        wr_bit  = (((loc ^ vch) & ~mch) == '0);
    end
endmodule

// File: rtl/tmt_prio.sv
// Priority encoder: reports whether any bit of the match vector is set,
// and the index of the lowest set bit (0 when none is set).
module tmt_prio #(
    parameter int SW = 8
) (
    input  logic [SW-1:0]         match,
    output logic                  hit,
    output logic [$clog2(SW)-1:0] idx
);
    localparam int RIW = $clog2(SW);

    // Scan from the top so that the lowest set bit is the one that sticks.
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = SW - 1; i >= 0; i--) begin
            if (match[i]) idx = RIW'(i);
        end
    end
endmodule

// File: rtl/tmt_match_table.sv
// SRAM-emulated ternary match table (top). The key is split into N slices.
// Each slice reads one word of its own sub-block, the N words are ANDed into
// a per-rule match vector, and the lowest matching rule is registered out one
// cycle after the search. Searches and updates are refused while an update
// walk is running. Assumes SD/N is a power of two with SD/N >= 2, and SW >= 2.
module tmt_match_table #(
    parameter int SD = 16,
    parameter int SW = 8,
    parameter int N  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       srch_vld,
    input  logic [N*$clog2(SD/N)-1:0]  srch_key,
    input  logic                       upd_vld,
    input  logic [$clog2(SW)-1:0]      upd_rule,
    input  logic [N*$clog2(SD/N)-1:0]  upd_value,
    input  logic [N*$clog2(SD/N)-1:0]  upd_mask,
    output logic                       busy,
    output logic                       res_vld,
    output logic                       res_hit,
    output logic [$clog2(SW)-1:0]      res_idx
);
    localparam int SUB = SD / N;
    localparam int CW  = $clog2(SUB);
    localparam int AW  = $clog2(SD);
    localparam int RIW = $clog2(SW);

    logic                 wr_en;
    logic [AW-1:0]        wr_addr;
    logic [RIW-1:0]       wr_rule;
    logic                 wr_bit;
    logic [N*AW-1:0]      rd_addr;
    logic [N*SW-1:0]      rd_rows;
    logic [SW-1:0]        match;
    logic                 enc_hit;
    logic [RIW-1:0]       enc_idx;
    logic                 srch_ok;

    assign srch_ok = srch_vld && !busy;

    // Slice i of the key addresses word i*SUB + slice.
    for (genvar i = 0; i < N; i++) begin : g_addr
        assign rd_addr[i*AW +: AW] = AW'(i * SUB) + AW'(srch_key[i*CW +: CW]);
    end

    // AND the N sub-block words into one match bit per rule.
    always_comb begin
        match = '1;
        for (int i = 0; i < N; i++) match &= rd_rows[i*SW +: SW];
    end

    tmt_store #(.SD(SD), .SW(SW), .N(N)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_rule (wr_rule),
        .wr_bit  (wr_bit),
        .rd_addr (rd_addr),
        .rd_rows (rd_rows)
    );

    tmt_updater #(.SD(SD), .SW(SW), .N(N)) u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (upd_vld),
        .rule    (upd_rule),
        .value   (upd_value),
        .mask    (upd_mask),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_rule (wr_rule),
        .wr_bit  (wr_bit)
    );

    tmt_prio #(.SW(SW)) u_prio (
        .match (match),
        .hit   (enc_hit),
        .idx   (enc_idx)
    );

    // Register the search result one cycle after an accepted search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            res_hit <= 1'b0;
            res_idx <= '0;
        end else begin
            res_vld <= srch_ok;
            if (srch_ok) begin
                res_hit <= enc_hit;
                res_idx <= enc_idx;
            end
        end
    end
endmodule

// File: rtl/tmt_match_table_chk.sv
// Protocol checker for tmt_match_table: result timing, the length of the
// update walk and the encoding of a miss.
module tmt_match_table_chk #(
    parameter int SD = 16,
    parameter int SW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  srch_vld,
    input logic                  upd_vld,
    input logic                  busy,
    input logic                  res_vld,
    input logic                  res_hit,
    input logic [$clog2(SW)-1:0] res_idx
);
    localparam int BW = $clog2(SD + 1);

    logic [BW-1:0] busy_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else busy_len <= '0;
    end

    // R6
    res_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(srch_vld && !busy));

    // R6
    res_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld && !busy) |=> res_vld);

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld && busy) |=> !res_vld);

    // R7
    upd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && !busy) |=> busy);

    // R7
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(upd_vld));

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == BW'(SD)));

    // R7
    busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < BW'(SD)));

    // R5
    miss_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_idx == '0));
endmodule

bind tmt_match_table tmt_match_table_chk #(.SD(SD), .SW(SW)) u_chk (.*);

// File: tb/tmt_match_table_bench.sv
// Self-checking bench for tmt_match_table: directed corner cases plus
// seeded random rules and keys, judged against a bench rule model.
module tmt_match_table_bench;
    localparam int SD  = 16;
    localparam int SW  = 8;
    localparam int N   = 2;
    localparam int CW  = $clog2(SD / N);
    localparam int KW  = N * CW;
    localparam int RIW = $clog2(SW);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           srch_vld = 1'b0;
    logic [KW-1:0]  srch_key = '0;
    logic           upd_vld = 1'b0;
    logic [RIW-1:0] upd_rule = '0;
    logic [KW-1:0]  upd_value = '0;
    logic [KW-1:0]  upd_mask = '0;
    logic           busy;
    logic           res_vld;
    logic           res_hit;
    logic [RIW-1:0] res_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit            m_vld [SW];
    logic [KW-1:0] m_val [SW];
    logic [KW-1:0] m_msk [SW];

    always #2 clk = ~clk;

    tmt_match_table #(.SD(SD), .SW(SW), .N(N)) u_tmt_match_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .srch_vld  (srch_vld),
        .srch_key  (srch_key),
        .upd_vld   (upd_vld),
        .upd_rule  (upd_rule),
        .upd_value (upd_value),
        .upd_mask  (upd_mask),
        .busy      (busy),
        .res_vld   (res_vld),
        .res_hit   (res_hit),
        .res_idx   (res_idx)
    );

    function automatic logic [RIW:0] model(input logic [KW-1:0] key);
        for (int r = 0; r < SW; r++)
            if (m_vld[r] && (((key ^ m_val[r]) & ~m_msk[r]) == '0))
                return {1'b1, RIW'(r)};
        return '0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_res(input string req, input logic [KW-1:0] key,
                             input logic [RIW:0] exp);
        check({req, " vld"}, int'(res_vld), 1);
        check({req, " hit"}, int'(res_hit), int'(exp[RIW]));
        check({req, " idx"}, int'(res_idx), int'(exp[RIW-1:0]));
    endtask

    task automatic search(input string req, input logic [KW-1:0] key);
        logic [RIW:0] exp;
        exp = model(key);
        @(negedge clk);
        srch_vld = 1'b1;
        srch_key = key;
        @(negedge clk);
        srch_vld = 1'b0;
        check_res(req, key, exp);
        @(negedge clk);
        check({req, " R6 single pulse"}, int'(res_vld), 0);
    endtask

    // Write a rule; optionally with a same-cycle search (R10) and with an
    // injected search and update in the middle of the walk (R8, R9).
    task automatic update(input logic [RIW-1:0] r, input logic [KW-1:0] v,
                          input logic [KW-1:0] m, input bit collide,
                          input logic [KW-1:0] ckey, input bit inject);
        logic [RIW:0] exp;
        int n;
        exp = model(ckey);
        @(negedge clk);
        upd_vld = 1'b1;
        upd_rule = r;
        upd_value = v;
        upd_mask = m;
        if (collide) begin
            srch_vld = 1'b1;
            srch_key = ckey;
        end
        @(negedge clk);
        upd_vld = 1'b0;
        srch_vld = 1'b0;
        m_vld[r] = 1'b1;
        m_val[r] = v;
        m_msk[r] = m;
        if (collide) check_res("R10 same-cycle search", ckey, exp);
        check("R7 busy after accept", int'(busy), 1);
        n = 0;
        while (busy) begin
            n++;
            if (inject && n == 3) begin
                upd_vld = 1'b1;
                upd_rule = r ^ RIW'(1);
                upd_value = ~v;
                upd_mask = '0;
                srch_vld = 1'b1;
                srch_key = v;
            end
            @(negedge clk);
            if (inject && n == 3) begin
                upd_vld = 1'b0;
                srch_vld = 1'b0;
                check("R8 search while busy", int'(res_vld), 0);
            end
            if (n > SD + 4) break;
        end
        check("R7 busy length", n, SD);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [KW-1:0] k;
        for (int r = 0; r < SW; r++) begin
            m_vld[r] = 1'b0;
            m_val[r] = '0;
            m_msk[r] = '0;
        end
        rv = $urandom(32'd7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 res_vld after reset", int'(res_vld), 0);
        search("R1 empty table", 6'h00);
        search("R1 empty table all-ones", 6'h3F);

        update(3'd5, 6'h2A, 6'h00, 1'b0, '0, 1'b0);
        search("R3 exact hit", 6'h2A);
        check("R3 exact hit idx", int'(res_idx), 5);
        search("R2 swapped slices", 6'h15);
        check("R2 swapped miss", int'(res_hit), 0);

        update(3'd2, 6'h28, 6'h07, 1'b0, '0, 1'b0);
        search("R4 two matches lowest", 6'h2A);
        check("R4 idx", int'(res_idx), 2);
        search("R3 dont-care bits", 6'h2F);
        search("R5 miss", 6'h00);

        // R10 with R8/R9 injection while the walk runs.
        update(3'd2, 6'h01, 6'h00, 1'b1, 6'h2A, 1'b1);
        search("R11 old pattern dropped", 6'h2F);
        check("R11 miss", int'(res_hit), 0);
        search("R11 new pattern", 6'h01);
        search("R9 injected rule absent", ~6'h01);
        check("R9 no hit", int'(res_hit), 0);
        search("R4 rule 5 still found", 6'h2A);

        for (int i = 0; i < 16; i++) begin
            rv = $urandom();
            update(RIW'(rv[2:0]), KW'(rv[13:8]), KW'(rv[21:16] & rv[29:24]),
                   rv[30], KW'($urandom()), 1'b0);
            for (int j = 0; j < 10; j++) begin
                rv = $urandom();
                k = KW'(rv[5:0]);
                if (rv[8] && m_vld[rv[11:9]])
                    k = m_val[rv[11:9]] ^ (m_msk[rv[11:9]] & KW'(rv[21:16]));
                search("R3/R4 random", k);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule